// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block prepares the second ALU operand before it reaches the adder or the logic unit. It takes a word, a three-bit shift-kind select, a shift distance and the current carry flag, and it returns the conditioned word together with a shifter carry for the flag logic. Five kinds of shift are available: shift left with zero fill, shift right with zero fill, shift right with sign fill, rotate right, and a one-bit rotate right through the carry flag.

Because the shifter feeds the adder input directly, one ALU pass can scale an operand by a power of two and add it to another. For example, a word plus itself shifted left by three gives nine times the word. Zero-fill right shifts divide unsigned values by powers of two, and sign-fill right shifts do the same for signed values. There is no rotate-left kind. A left rotate by k is requested as a right rotate by the word width minus k. The block is purely combinational and adds no pipeline stage.

Top module: `barrel_shift_top`

## Requirements
- R1: Kind code 0 shifts left by n (1..31). Vacated low bits are zero, and carryOut is input bit 32-n.
- R2: Kind code 1 shifts right by n (1..31). Vacated high bits are zero, and carryOut is input bit n-1.
- R3: Kind code 2 shifts right by n (1..31). Vacated high bits copy input bit 31, and carryOut is input bit n-1.
- R4: Kind code 3 rotates right by n (1..31). Bits leaving at bit 0 re-enter at bit 31, and carryOut equals result bit 31.
- R5: Kind code 4 rotates right by one through the carry. carryIn goes to result bit 31, input bit 0 becomes carryOut, and shAmt has no effect.
- R6: For kind codes 0 to 3 with shAmt equal to 0, opOut equals opIn and carryOut equals carryIn.
- R7: Kind codes 5, 6 and 7 pass opIn to opOut unchanged and give carryOut equal to carryIn.
- R8: The outputs follow the inputs with no register on the path, so a new input shows at the outputs before the next clock edge.
- R9: A right rotate by 32-k gives the same word as a left rotate by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 32 | Operand word to be conditioned |
| kindSel | input | 3 | Shift kind: 0 left, 1 right zero fill, 2 right sign fill, 3 rotate right, 4 rotate through carry |
| shAmt | input | 5 | Shift distance, 0 to 31 |
| carryIn | input | 1 | Current carry flag |
| opOut | output | 32 | Conditioned operand |
| carryOut | output | 1 | Shifter carry for the flags |

## Verification
The block holds no state, so a fault in its internals can only be a wrong control strobe or a wrong stage connection. Such a fault shows on opOut or carryOut at once, in the same cycle that the bad kind or distance is applied. One bad log stage corrupts only the distances that have that bit set. For this reason the bench sweeps every distance for every kind, and it also checks the carry, because the carry flag picks up a fault that can leave the shifted word looking plausible.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  // Kind codes seen on kindSel; the numeric values are part of the interface.
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shiftKind_t;

  // What enters the vacated high positions of each right-shift stage.
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fillMode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic      mirror;  // reverse the word around the right-shift core
    fillMode_t fill;
    logic      extRot;  // single-step rotate through carry
    logic      bypass;  // reserved code: pass through
  } shiftCtrl_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
(
  input  logic [2:0] kindSel,
  output shiftCtrl_t ctrl
);

  always_comb begin
    ctrl = '{mirror: 1'b0, fill: FILL_ZERO, extRot: 1'b0, bypass: 1'b0};
    case (kindSel)
      SK_LSL:  ctrl.mirror = 1'b1;
      SK_LSR:  ctrl.fill   = FILL_ZERO;
      SK_ASR:  ctrl.fill   = FILL_SIGN;
      SK_ROR:  ctrl.fill   = FILL_WRAP;
      SK_RRX:  ctrl.extRot = 1'b1;
      default: ctrl.bypass = 1'b1;
    endcase
  end

endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opIn,
  input  logic [AMT_W-1:0]  shAmt,
  input  logic              carryIn,
  input  shiftCtrl_t        ctrl,
  output logic [DATA_W-1:0] opOut,
  output logic              carryOut
);

  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] coreWord;
  logic [DATA_W-1:0] fixedWord;
  logic [EXT_W-1:0]  coreOut;
  logic              signBit;

  assign signBit = opIn[DATA_W-1];

  // Left shifts run through the right-shift core on a mirrored word.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      srcWord[i] = ctrl.mirror ? opIn[DATA_W-1-i] : opIn[i];
    end
  end

  // Log stages on {word, guard}; the guard ends up holding the last bit out.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [EXT_W-1:0] cur;
    logic [EXT_W-1:0] nxt;
    logic [STEP-1:0]  fillBits;

    if (k == 0) begin : g_first
      assign cur = {srcWord, carryIn};
    end else begin : g_next
      assign cur = g_stage[k-1].nxt;
    end

    always_comb begin
      case (ctrl.fill)
        FILL_SIGN: fillBits = {STEP{signBit}};
        FILL_WRAP: fillBits = cur[STEP:1];
        default:   fillBits = '0;
      endcase
    end

    assign nxt = shAmt[k] ? {fillBits, cur[EXT_W-1:STEP]} : cur;
  end

  assign coreOut  = g_stage[AMT_W-1].nxt;
  assign coreWord = coreOut[EXT_W-1:1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      fixedWord[i] = ctrl.mirror ? coreWord[DATA_W-1-i] : coreWord[i];
    end
  end

  always_comb begin
    if (ctrl.bypass) begin
      opOut    = opIn;
      carryOut = carryIn;
    end else if (ctrl.extRot) begin
      opOut    = {carryIn, opIn[DATA_W-1:1]};
      carryOut = opIn[0];
    end else begin
      opOut    = fixedWord;
      carryOut = coreOut[0];
    end
  end

endmodule

// File: rtl/barrel_shift_top.sv
module barrel_shift_top
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opIn,
  input  logic [2:0]        kindSel,
  input  logic [AMT_W-1:0]  shAmt,
  input  logic              carryIn,
  output logic [DATA_W-1:0] opOut,
  output logic              carryOut
);

  shiftCtrl_t ctrl;

  bshift_ctrl u_ctrl (
    .kindSel (kindSel),
    .ctrl    (ctrl)
  );

  bshift_datapath #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_dp (
    .opIn     (opIn),
    .shAmt    (shAmt),
    .carryIn  (carryIn),
    .ctrl     (ctrl),
    .opOut    (opOut),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opIn,
  input logic [2:0]        kindSel,
  input logic [AMT_W-1:0]  shAmt,
  input logic              carryIn,
  input logic [DATA_W-1:0] opOut,
  input logic              carryOut
);

  always_comb begin
    if (kindSel == 3'd0 && shAmt != '0) begin
      p_left_carry_r1: assert (carryOut == opIn[DATA_W - int'(shAmt)] && opOut[0] == 1'b0)
        else $error("left shift carry or fill wrong");
    end
    if (kindSel == 3'd1 && shAmt != '0) begin
      p_right_zero_r2: assert (opOut[DATA_W-1] == 1'b0 && carryOut == opIn[int'(shAmt) - 1])
        else $error("zero-fill right shift wrong");
    end
    if (kindSel == 3'd2) begin
      p_sign_keep_r3: assert (opOut[DATA_W-1] == opIn[DATA_W-1])
        else $error("sign-fill shift lost sign");
    end
    if (kindSel == 3'd3) begin
      p_rot_ones_r4: assert ($countones(opOut) == $countones(opIn))
        else $error("rotate changed bit count");
    end
    if (kindSel == 3'd4) begin
      p_ext_rot_r5: assert (opOut[DATA_W-1] == carryIn && carryOut == opIn[0])
        else $error("rotate through carry wrong");
    end
    if ((kindSel <= 3'd3 && shAmt == '0) || kindSel >= 3'd5) begin
      p_pass_r6_r7: assert (opOut == opIn && carryOut == carryIn)
        else $error("pass-through altered value or carry");
    end
  end

endmodule

bind barrel_shift_top bshift_chk #(
  .DATA_W (DATA_W),
  .AMT_W  (AMT_W)
) u_chk (
  .opIn     (opIn),
  .kindSel  (kindSel),
  .shAmt    (shAmt),
  .carryIn  (carryIn),
  .opOut    (opOut),
  .carryOut (carryOut)
);

// File: tb/test_barrel_shift_top.sv
module test_barrel_shift_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opIn = '0;
  logic [2:0]   kindSel = '0;
  logic [4:0]   shAmt = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] opOut;
  logic         carryOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_top i_barrel_shift_top (
    .opIn     (opIn),
    .kindSel  (kindSel),
    .shAmt    (shAmt),
    .carryIn  (carryIn),
    .opOut    (opOut),
    .carryOut (carryOut)
  );

  // Behavioural reference, bit by bit.
  function automatic void refShift(input logic [W-1:0] v, input int k, input int n,
                                   input logic c, output logic [W-1:0] r, output logic co);
    r  = v;
    co = c;
    if (k == 4) begin
      r  = {c, v[W-1:1]};
      co = v[0];
    end else if (k <= 3 && n != 0) begin
      for (int i = 0; i < W; i++) begin
        case (k)
          0: r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
          1: r[i] = (i + n < W) ? v[i+n] : 1'b0;
          2: r[i] = (i + n < W) ? v[i+n] : v[W-1];
          default: r[i] = v[(i + n) % W];
        endcase
      end
      if (k == 0) co = v[W-n];
      else if (k == 3) co = r[W-1];
      else co = v[n-1];
    end
  endfunction

  function automatic string tagOf(input int k, input int n);
    if (k >= 5) return "R7";
    if (k <= 3 && n == 0) return "R6";
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic checkEq(input string tag, input logic [W-1:0] gotW, input logic [W-1:0] expW,
                         input logic gotC, input logic expC);
    checks++;
    if (gotW !== expW || gotC !== expC) begin
      errors++;
      $display("FAIL %s: got %08h c=%0b expected %08h c=%0b", tag, gotW, gotC, expW, expC);
    end
  endtask

  // Drive on the rising edge, compare at the falling edge.
  task automatic apply(input logic [W-1:0] v, input int k, input int n, input logic c);
    logic [W-1:0] er;
    logic         ec;
    @(posedge clk);
    opIn = v; kindSel = 3'(k); shAmt = 5'(n); carryIn = c;
    @(negedge clk);
    refShift(v, k, n, c, er, ec);
    checkEq(tagOf(k, n), opOut, er, carryOut, ec);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8: watchdog expired, got no end expected end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] sumW;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R6", opOut, '0, carryOut, 1'b0);  // reset-time state, all zero inputs
    rst = 1'b0;

    apply(32'h1234_5678, 0, 4, 1'b0);   // R1
    apply(32'h8000_0001, 0, 1, 1'b0);   // R1 carry from bit 31
    apply(32'h1234_5678, 1, 8, 1'b1);   // R2
    apply(32'h8765_4321, 2, 4, 1'b0);   // R3 negative
    apply(32'h7FFF_FFFF, 2, 31, 1'b0);  // R3 boundary
    apply(32'h1234_5678, 3, 8, 1'b0);   // R4
    apply(32'h0000_0001, 3, 1, 1'b0);   // R4 carry equals msb
    apply(32'h1234_5679, 4, 17, 1'b1);  // R5 distance ignored
    apply(32'hDEAD_BEEF, 3, 0, 1'b1);   // R6
    apply(32'hCAFE_F00D, 6, 9, 1'b1);   // R7

    // R1: adder use, x + (x << 3) == 9x
    @(posedge clk);
    opIn = 32'h0001_2345; kindSel = 3'd0; shAmt = 5'd3; carryIn = 1'b0;
    @(negedge clk);
    sumW = opIn + opOut;
    checkEq("R1", sumW, 32'h0001_2345 * 9, carryOut, 1'b0);

    // R9: left rotate by k as right rotate by 32-k
    for (int k = 1; k < W; k++) begin
      logic [W-1:0] v;
      v = 32'hA5C3_0F96;
      @(posedge clk);
      opIn = v; kindSel = 3'd3; shAmt = 5'(W - k); carryIn = 1'b0;
      @(negedge clk);
      checkEq("R9", opOut, (v << k) | (v >> (W - k)), carryOut, v[0 + (W - k) - 1]);
    end

    // R8: output follows input within the same cycle, before any edge
    @(posedge clk);
    opIn = 32'h0000_00F0; kindSel = 3'd1; shAmt = 5'd4; carryIn = 1'b0;
    #1;
    checkEq("R8", opOut, 32'h0000_000F, carryOut, 1'b0);
    opIn = 32'h0000_0F00;
    #1;
    checkEq("R8", opOut, 32'h0000_00F0, carryOut, 1'b0);

    // Full sweep of kinds and distances on several patterns
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat;
      case (p)
        0: pat = 32'h8000_0000;
        1: pat = 32'h0000_0001;
        2: pat = 32'hF0F0_3C3C;
        default: pat = 32'h5A5A_A5A5;
      endcase
      for (int k = 0; k < 8; k++) begin
        for (int n = 0; n < W; n++) begin
          apply(pat, k, n, n[0]);
        end
      end
    end

    // Pseudo-random vectors
    for (int i = 0; i < 2000; i++) begin
      apply($urandom, int'($urandom_range(0, 7)), int'($urandom_range(0, 31)), 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule